// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits next to a network receive path and decides when the host should be interrupted for received frames. Instead of raising an interrupt per frame, it gathers completed frames into a bundle. One interrupt then covers the whole bundle. A bundle closes when either of two things happens first: its frame count reaches a programmable cap, or a dead-man countdown expires.

Short frames, such as TCP acknowledgements, would be delayed by bundling. A frame whose length gives zero when ANDed with a programmable bit mask is therefore treated as short. It interrupts the host at once and leaves the open bundle untouched.

Three 16-bit configuration words drive the block:
- a countdown reload value, which counts in tick-enable pulses;
- a bundle frame cap;
- a short-frame mask.

The countdown reload value and the cap are captured when a bundle opens. Edits to them made while a bundle is open take effect only from the next bundle. The interrupt request is a level signal. It stays high until the host acknowledges it.

Top module: `rxcoal_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0 and `bundle_cnt` is 0.
- R2: A frame that is not short, arriving while `bundle_cnt` is 0, opens a bundle. From the next cycle `bundle_cnt` is 1. Each further such frame adds 1.
- R3: When the count of a bundle reaches its captured cap, `irq_req` rises in the next cycle and `bundle_cnt` returns to 0 in that same cycle. With a cap of 6, the sixth frame closes the bundle.
- R4: With a cap of 1, every frame that is not short raises `irq_req`, and `bundle_cnt` stays 0.
- R5: A cap of 0xFFFF disables the frame cap. Any number of frames accumulates, and only the countdown closes the bundle.
- R6: A frame is short when `(frm_len & cfg_short_mask) == 0`. With mask 0xFF80, this means lengths of 127 or less. A short frame raises `irq_req` in the next cycle. It is not counted and leaves `bundle_cnt` and the countdown unchanged.
- R7: Mask 0xFFFF makes no frame of nonzero length short. Mask 0xF800 makes every length up to 2047 short, while a length of 2048 is bundled.
- R8: The countdown loads the captured reload value when a bundle opens. A tick in the opening cycle is ignored. The bundle then closes on the Nth later cycle with `tick_en` high, where N is the reload value and 0 acts as 1. Cycles without a tick do not count.
- R9: `irq_req` stays high until `irq_ack` is seen. An ack clears it in the next cycle, unless a new interrupt cause occurs in the same cycle as the ack.
- R10: A countdown close and a short frame in the same cycle raise a single request, which one ack clears.
- R11: Changes to the cap and the reload value while a bundle is open do not affect that bundle. They apply from the next bundle opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Countdown decrement pulse |
| frm_done | input | 1 | One-cycle strobe: a frame has been received |
| frm_len | input | 16 | Length in bytes of the completed frame |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| cfg_reload | input | 16 | Countdown reload value |
| cfg_cap | input | 16 | Bundle frame cap (0xFFFF = unlimited) |
| cfg_short_mask | input | 16 | Short-frame length mask |
| irq_req | output | 1 | Interrupt request level |
| bundle_cnt | output | 16 | Frames pending in the open bundle |

## Verification
The hardest situation to reach is one where a countdown expiry coincides with a short frame, or where configuration changes in the middle of a bundle. Both depend on lining up the open bundle's state with a single input cycle.

The bench reaches the coincident case by loading a small reload value, opening a bundle, and issuing the final tick on the same cycle as a short frame. It reaches the mid-bundle case by rewriting the cap and the reload value between two frames of one bundle. It then shows that the old cap and countdown still govern that bundle, and that the new values govern the next one.

// File: rtl/rxcoal_pkg.sv
package rxcoal_pkg;

    localparam int unsigned PW = 16;

    typedef logic [PW-1:0] word_t;

    localparam word_t CAP_UNLIMITED = '1;

    typedef struct packed {
        logic valid;
        logic is_short;
    } frame_evt_t;

    typedef struct packed {
        logic take;
        logic short_evt;
    } frame_route_t;

    function automatic logic is_short_frame(input word_t len, input word_t mask);
        return (len & mask) == '0;
    endfunction

    function automatic word_t sat_inc(input word_t v);
        return (v == '1) ? v : v + word_t'(1);
    endfunction

    function automatic word_t eff_reload(input word_t v);
        return (v == '0) ? word_t'(1) : v;
    endfunction

endpackage

// File: rtl/rxcoal_classify.sv
module rxcoal_classify
    import rxcoal_pkg::*;
(
    input  logic         frm_done,
    input  word_t        frm_len,
    input  word_t        mask,
    output frame_route_t route
);
    frame_evt_t evt;

    always_comb begin
        evt.valid    = frm_done;
        evt.is_short = is_short_frame(frm_len, mask);
        route.take      = evt.valid && !evt.is_short;
        route.short_evt = evt.valid &&  evt.is_short;
    end
endmodule

// File: rtl/rxcoal_timer.sv
module rxcoal_timer
    import rxcoal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t reload,
    input  logic  stop,
    input  logic  tick,
    output logic  expire
);
    word_t tmr_q;
    logic  run_q;

    assign expire = run_q && tick && (tmr_q <= word_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            run_q <= 1'b0;
        end else if (stop) begin
            tmr_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            tmr_q <= eff_reload(reload);
            run_q <= 1'b1;
        end else if (run_q && tick) begin
            tmr_q <= tmr_q - word_t'(1);
        end
    end

    // A running countdown never sits at zero.
    assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (tmr_q != '0));

    // A tick on a running countdown that does not expire lowers it by one.
    assert_tick_dec_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && !expire && !stop && !load) |=> (tmr_q == $past(tmr_q) - word_t'(1)));
endmodule

// File: rtl/rxcoal_bundle.sv
module rxcoal_bundle
    import rxcoal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  expire,
    input  word_t cfg_cap,
    output word_t cnt,
    output logic  start,
    output logic  cap_close,
    output logic  close
);
    word_t cnt_q;
    word_t cap_q;
    word_t cnt_next;
    word_t cap_eff;

    always_comb begin
        start     = take && (cnt_q == '0);
        cnt_next  = sat_inc(cnt_q);
        cap_eff   = start ? cfg_cap : cap_q;
        cap_close = take && (cap_eff != CAP_UNLIMITED) && (cnt_next >= cap_eff);
        close     = cap_close || expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            if (start)
                cap_q <= cfg_cap;
            if (close)
                cnt_q <= '0;
            else if (take)
                cnt_q <= cnt_next;
        end
    end

    assign cnt = cnt_q;

    assert_cnt_below_cap_R3: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q != '0) && (cap_q != CAP_UNLIMITED)) |-> (cnt_q < cap_q));

    assert_close_clears_R3: assert property (@(posedge clk) disable iff (rst)
        close |=> (cnt_q == '0));

    assert_cap_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (($past(cnt_q) != '0) && (cnt_q != '0)) |-> $stable(cap_q));

    assert_open_one_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !close) |=> (cnt_q == word_t'(1)));
endmodule

// File: rtl/rxcoal_irq.sv
module rxcoal_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (set)
            irq_q <= 1'b1;
        else if (ack)
            irq_q <= 1'b0;
    end

    assign irq = irq_q;

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack) |=> irq_q);

    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !set) |=> !irq_q);
endmodule

// File: rtl/rxcoal_ctrl.sv
module rxcoal_ctrl
    import rxcoal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        frm_done,
    input  logic [15:0] frm_len,
    input  logic        irq_ack,
    input  logic [15:0] cfg_reload,
    input  logic [15:0] cfg_cap,
    input  logic [15:0] cfg_short_mask,
    output logic        irq_req,
    output logic [15:0] bundle_cnt
);
    frame_route_t route;
    word_t        cnt;
    logic         start;
    logic         cap_close;
    logic         close;
    logic         expire;

    rxcoal_classify u_classify (
        .frm_done (frm_done),
        .frm_len  (frm_len),
        .mask     (cfg_short_mask),
        .route    (route)
    );

    rxcoal_bundle u_bundle (
        .clk       (clk),
        .rst       (rst),
        .take      (route.take),
        .expire    (expire),
        .cfg_cap   (cfg_cap),
        .cnt       (cnt),
        .start     (start),
        .cap_close (cap_close),
        .close     (close)
    );

    rxcoal_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (start && !cap_close),
        .reload (cfg_reload),
        .stop   (close),
        .tick   (tick_en),
        .expire (expire)
    );

    rxcoal_irq u_irq (
        .clk (clk),
        .rst (rst),
        .set (close || route.short_evt),
        .ack (irq_ack),
        .irq (irq_req)
    );

    assign bundle_cnt = cnt;

    assert_short_keeps_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        (route.short_evt && !expire) |=> (bundle_cnt == $past(bundle_cnt)));

    assert_short_raises_R6: assert property (@(posedge clk) disable iff (rst)
        route.short_evt |=> irq_req);

    assert_expire_open_R8: assert property (@(posedge clk) disable iff (rst)
        expire |-> (bundle_cnt != '0));
endmodule

// File: tb/rxcoal_ctrl_bench.sv
module rxcoal_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        frm_done = 1'b0;
    logic [15:0] frm_len = '0;
    logic        irq_ack = 1'b0;
    logic [15:0] cfg_reload = 16'h0600;
    logic [15:0] cfg_cap = 16'd6;
    logic [15:0] cfg_short_mask = 16'hFF80;
    logic        irq_req;
    logic [15:0] bundle_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rxcoal_ctrl u_rxcoal_ctrl (
        .clk(clk), .rst(rst), .tick_en(tick_en), .frm_done(frm_done),
        .frm_len(frm_len), .irq_ack(irq_ack), .cfg_reload(cfg_reload),
        .cfg_cap(cfg_cap), .cfg_short_mask(cfg_short_mask),
        .irq_req(irq_req), .bundle_cnt(bundle_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic fv, input int len, input logic tk, input logic ack);
        @(negedge clk);
        frm_done = fv;
        frm_len  = 16'(len);
        tick_en  = tk;
        irq_ack  = ack;
        @(posedge clk);
        #1;
        @(negedge clk);
        frm_done = 1'b0;
        tick_en  = 1'b0;
        irq_ack  = 1'b0;
        #1;
    endtask

    task automatic do_reset(input int reload, input int cap, input int mask);
        @(negedge clk);
        rst = 1'b1;
        cfg_reload = 16'(reload);
        cfg_cap = 16'(cap);
        cfg_short_mask = 16'(mask);
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset('h600, 6, 'hFF80);
        chk("R1 irq after reset", int'(irq_req), 0);
        chk("R1 count after reset", int'(bundle_cnt), 0);
    endtask

    task automatic t_cap_default;
        do_reset('h600, 6, 'hFF80);
        cyc(1, 200, 0, 0);
        chk("R2 first frame opens", int'(bundle_cnt), 1);
        for (int i = 2; i <= 5; i++) cyc(1, 200, 0, 0);
        chk("R2 count after five", int'(bundle_cnt), 5);
        chk("R3 no irq before cap", int'(irq_req), 0);
        cyc(1, 200, 0, 0);
        chk("R3 irq at cap", int'(irq_req), 1);
        chk("R3 count cleared at cap", int'(bundle_cnt), 0);
    endtask

    task automatic t_cap_one;
        do_reset('h600, 1, 'hFF80);
        cyc(1, 500, 0, 0);
        chk("R4 irq per frame", int'(irq_req), 1);
        chk("R4 count stays zero", int'(bundle_cnt), 0);
        cyc(0, 0, 0, 1);
        chk("R4 acked", int'(irq_req), 0);
        cyc(1, 900, 0, 0);
        chk("R4 irq second frame", int'(irq_req), 1);
    endtask

    task automatic t_nocap;
        do_reset(4, 'hFFFF, 'hFF80);
        for (int i = 0; i < 10; i++) cyc(1, 300, 0, 0);
        chk("R5 ten frames held", int'(bundle_cnt), 10);
        chk("R5 no irq without cap", int'(irq_req), 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
        chk("R5 pending before last tick", int'(irq_req), 0);
        cyc(0, 0, 1, 0);
        chk("R5 timer closes", int'(irq_req), 1);
        chk("R5 count cleared", int'(bundle_cnt), 0);
    endtask

    task automatic t_short;
        do_reset('h600, 6, 'hFF80);
        cyc(1, 300, 0, 0);
        cyc(1, 300, 0, 0);
        cyc(1, 127, 0, 0);
        chk("R6 short irq", int'(irq_req), 1);
        chk("R6 short not counted", int'(bundle_cnt), 2);
        cyc(0, 0, 0, 1);
        chk("R6 ack clears", int'(irq_req), 0);
        cyc(1, 128, 0, 0);
        chk("R6 128 bundled", int'(bundle_cnt), 3);
        chk("R6 128 no irq", int'(irq_req), 0);
    endtask

    task automatic t_mask_modes;
        do_reset('h600, 6, 'hFFFF);
        cyc(1, 1, 0, 0);
        chk("R7 mask FFFF len1 bundled", int'(bundle_cnt), 1);
        chk("R7 mask FFFF no irq", int'(irq_req), 0);
        @(negedge clk);
        cfg_short_mask = 16'hF800;
        cyc(1, 2047, 0, 0);
        chk("R7 mask F800 2047 irq", int'(irq_req), 1);
        chk("R7 mask F800 count kept", int'(bundle_cnt), 1);
        cyc(1, 2048, 0, 1);
        chk("R7 mask F800 2048 bundled", int'(bundle_cnt), 2);
        chk("R7 2048 no irq", int'(irq_req), 0);
    endtask

    task automatic t_timer;
        do_reset(3, 6, 'hFF80);
        cyc(1, 400, 1, 0);
        chk("R8 opening tick ignored", int'(bundle_cnt), 1);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 0);
        chk("R8 two ticks no close", int'(irq_req), 0);
        chk("R8 still open", int'(bundle_cnt), 1);
        cyc(0, 0, 1, 0);
        chk("R8 third tick closes", int'(irq_req), 1);
        chk("R8 count cleared", int'(bundle_cnt), 0);
    endtask

    task automatic t_ack;
        do_reset('h600, 6, 'hFF80);
        cyc(1, 60, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);
        chk("R9 irq held", int'(irq_req), 1);
        cyc(1, 60, 0, 1);
        chk("R9 new cause beats ack", int'(irq_req), 1);
        cyc(0, 0, 0, 1);
        chk("R9 ack clears", int'(irq_req), 0);
    endtask

    task automatic t_coincide;
        do_reset(2, 6, 'hFF80);
        cyc(1, 300, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(1, 40, 1, 0);
        chk("R10 irq on coincident", int'(irq_req), 1);
        chk("R10 bundle closed", int'(bundle_cnt), 0);
        cyc(0, 0, 0, 1);
        chk("R10 one ack clears", int'(irq_req), 0);
        cyc(0, 0, 0, 0);
        chk("R10 stays clear", int'(irq_req), 0);
    endtask

    task automatic t_param_change;
        do_reset('h600, 3, 'hFF80);
        cyc(1, 300, 0, 0);
        @(negedge clk);
        cfg_cap = 16'd1;
        cfg_reload = 16'd2;
        cyc(1, 300, 0, 0);
        chk("R11 new cap ignored mid bundle", int'(bundle_cnt), 2);
        chk("R11 no irq mid bundle", int'(irq_req), 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        chk("R11 new reload ignored", int'(irq_req), 0);
        cyc(1, 300, 0, 0);
        chk("R11 old cap closes", int'(irq_req), 1);
        cyc(0, 0, 0, 1);
        cyc(1, 300, 0, 0);
        chk("R11 new cap at next bundle", int'(irq_req), 1);
        chk("R11 cap1 count zero", int'(bundle_cnt), 0);
        cyc(0, 0, 0, 1);
        @(negedge clk);
        cfg_cap = 16'd6;
        cyc(1, 300, 0, 0);
        cyc(0, 0, 1, 0);
        chk("R11 reload2 first tick", int'(irq_req), 0);
        cyc(0, 0, 1, 0);
        chk("R11 reload2 closes", int'(irq_req), 1);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_cap_default();
        t_cap_one();
        t_nocap();
        t_short();
        t_mask_modes();
        t_timer();
        t_ack();
        t_coincide();
        t_param_change();
        summary();
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule